// File: doc/BRIEF.md
# Keyed Instruction-Memory Write Window

This block sits on a processor's data-side write bus and opens a narrow path into the separate instruction memory. Three registers in the upper IO half of the data space make up the window. One holds a lock that opens only when a fixed 32-bit key value is written to it. One holds a pointer into instruction memory. The third is a data port: each write to it, while the lock is open, becomes one write into instruction memory.

The pointer moves forward by four after every accepted data write. Software can therefore stream a program image into instruction memory with repeated stores to a single register. Each write goes out on a registered strobe interface that carries the aligned address, the data replicated into the byte lanes, byte enables and the size code. The instruction memory itself, reads from it, and the other devices in the IO region belong to other blocks.

Top module: `pmw_port`

## Requirements
- R1: After synchronous reset the lock is closed, the pointer is zero and `pm_we` is low. A data-port write issued before any key write produces no strobe. The first accepted write after unlocking goes to address 0.
- R2: A bus write to offset 0x1FC80 opens the lock when the written value equals the KEY parameter (default 0x1337F7D1). Any other value closes it, and data-port writes are then ignored until the key is written again.
- R3: A bus write to offset 0x1FC88 while the lock is open makes `pm_we` high for exactly the next cycle. With that strobe come the pointer's value before the write, the written data and the bus size. While the lock is closed the write produces no strobe.
- R4: A bus write to offset 0x1FC84 loads the pointer with the written value. Each accepted data-port write adds 4 to the pointer, whatever its size, and the pointer wraps modulo 2^PTR_W. A data-port write while locked leaves the pointer unchanged.
- R5: `pm_addr` is the low PM_AW bits of the pointer. Bit 0 is cleared for halfword writes, bits 1:0 are cleared for word writes, and byte writes use the pointer unchanged.
- R6: Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is handled as a word. A byte write enables lane `pm_addr[1:0]` and repeats data bits 7:0 in all four lanes. A halfword write enables lanes 1:0 or 3:2 according to `pm_addr[1]` and repeats bits 15:0 twice. A word write enables all four lanes and passes the data unchanged.
- R7: Only address bits 16:0 are decoded, so higher bits are ignored. A write with bit 16 clear, or to any other offset in the IO half, changes neither the lock nor the pointer and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Data-bus write valid |
| bus_addr | input | BUS_AW | Data-bus byte address |
| bus_wdata | input | 32 | Data-bus write value |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 as word) |
| pm_we | output | 1 | Instruction-memory write strobe, one cycle per write |
| pm_addr | output | PM_AW | Aligned instruction-memory byte address |
| pm_wdata | output | 32 | Write data replicated into the byte lanes |
| pm_be | output | 4 | Byte-lane enables |
| pm_size | output | 2 | Size code of the write |

## Verification
Key and pointer writes take effect at the clock edge that samples them, so a data-port write issued in the very next cycle already sees them. The strobe and its address, data and enables appear one cycle after the data-port write and stay for one cycle only. The bench drives each bus write just after a falling edge. It samples the outputs at the following falling edge, which lies one rising edge after the write, and then drives the next write at once, so consecutive writes reach the design back to back. An idle cycle after the table checks that the strobe has dropped again.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int WIN_W  = 17;

    localparam logic [WIN_W-1:0] OFF_LOCK = 17'h1FC80;
    localparam logic [WIN_W-1:0] OFF_PTR  = 17'h1FC84;
    localparam logic [WIN_W-1:0] OFF_DATA = 17'h1FC88;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOCK = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        size_e             size;
    } beat_t;

    function automatic logic [1:0] align_low(size_e s, logic [1:0] a);
        logic [1:0] r;
        case (s)
            SZ_BYTE: r = a;
            SZ_HALF: r = {a[1], 1'b0};
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(size_e s, logic [1:0] a);
        logic [LANES-1:0] m;
        case (s)
            SZ_BYTE: m = LANES'(1) << a;
            SZ_HALF: m = a[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_data(size_e s, logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        case (s)
            SZ_BYTE: r = {LANES{d[7:0]}};
            SZ_HALF: r = {2{d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pmw_decode.sv
module pmw_decode
    import pmw_pkg::*;
#(
    parameter int BUS_AW = 32
) (
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    output sel_e              sel
);

    logic [WIN_W-1:0] win;

    always_comb begin
        win = wr_addr[WIN_W-1:0];
        sel = SEL_NONE;
        if (wr_en && win[WIN_W-1]) begin
            case (win)
                OFF_LOCK: sel = SEL_LOCK;
                OFF_PTR:  sel = SEL_PTR;
                OFF_DATA: sel = SEL_DATA;
                default:  sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pmw_key_latch.sv
module pmw_key_latch
    import pmw_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY = 32'h1337F7D1
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (sel == SEL_LOCK) begin
            open_q <= (wdata == KEY);
        end
    end

endmodule

// File: rtl/pmw_addr_ptr.sv
module pmw_addr_ptr
    import pmw_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_e              sel,
    input  logic              open_q,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr_q
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(LANES);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (sel == SEL_PTR) begin
            ptr_q <= wdata[PTR_W-1:0];
        end else if (sel == SEL_DATA && open_q) begin
            ptr_q <= ptr_q + STEP;
        end
    end

endmodule

// File: rtl/pmw_strobe_gen.sv
module pmw_strobe_gen
    import pmw_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int PM_AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [PTR_W-1:0]  ptr,
    input  beat_t             beat,
    output logic              pm_we,
    output logic [PM_AW-1:0]  pm_addr,
    output logic [DATA_W-1:0] pm_wdata,
    output logic [LANES-1:0]  pm_be,
    output logic [1:0]        pm_size
);

    logic [PM_AW-1:0] addr_al;

    always_comb begin
        addr_al      = ptr[PM_AW-1:0];
        addr_al[1:0] = align_low(beat.size, ptr[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_we    <= 1'b0;
            pm_addr  <= '0;
            pm_wdata <= '0;
            pm_be    <= '0;
            pm_size  <= '0;
        end else begin
            pm_we <= fire;
            if (fire) begin
                pm_addr  <= addr_al;
                pm_wdata <= lane_data(beat.size, beat.data);
                pm_be    <= lane_mask(beat.size, addr_al[1:0]);
                pm_size  <= beat.size;
            end
        end
    end

endmodule

// File: rtl/pmw_port.sv
module pmw_port
    import pmw_pkg::*;
#(
    parameter int                BUS_AW = 32,
    parameter int                PTR_W  = 32,
    parameter int                PM_AW  = 18,
    parameter logic [DATA_W-1:0] KEY    = 32'h1337F7D1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    output logic              pm_we,
    output logic [PM_AW-1:0]  pm_addr,
    output logic [31:0]       pm_wdata,
    output logic [3:0]        pm_be,
    output logic [1:0]        pm_size
);

    sel_e             sel;
    logic             key_ok;
    logic [PTR_W-1:0] ptr;
    logic             fire;
    beat_t            beat;

    assign beat.data = bus_wdata;
    assign beat.size = size_e'(bus_size);
    assign fire      = (sel == SEL_DATA) && key_ok;

    pmw_decode #(.BUS_AW(BUS_AW)) u_dec (
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .sel     (sel)
    );

    pmw_key_latch #(.KEY(KEY)) u_key (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wdata  (bus_wdata),
        .open_q (key_ok)
    );

    pmw_addr_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .open_q (key_ok),
        .wdata  (bus_wdata),
        .ptr_q  (ptr)
    );

    pmw_strobe_gen #(.PTR_W(PTR_W), .PM_AW(PM_AW)) u_stb (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .ptr      (ptr),
        .beat     (beat),
        .pm_we    (pm_we),
        .pm_addr  (pm_addr),
        .pm_wdata (pm_wdata),
        .pm_be    (pm_be),
        .pm_size  (pm_size)
    );

endmodule

// File: rtl/pmw_port_chk.sv
module pmw_port_chk #(
    parameter int BUS_AW = 32,
    parameter int PM_AW  = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              unlocked,
    input logic              pm_we,
    input logic [PM_AW-1:0]  pm_addr,
    input logic [31:0]       pm_wdata,
    input logic [3:0]        pm_be,
    input logic [1:0]        pm_size
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !pm_we);

    p_we_source_r3: assert property (@(posedge clk) disable iff (rst)
        pm_we |-> $past(bus_we && bus_addr[16:0] == 17'h1FC88 && unlocked));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (pm_we && $past(pm_we) && pm_size == 2'd2 && $past(pm_size) == 2'd2)
        |-> pm_addr == PM_AW'($past(pm_addr) + PM_AW'(4)));

    p_align_half_r5: assert property (@(posedge clk) disable iff (rst)
        (pm_we && pm_size == 2'd1) |-> !pm_addr[0]);

    p_align_word_r5: assert property (@(posedge clk) disable iff (rst)
        (pm_we && pm_size[1]) |-> pm_addr[1:0] == 2'b00);

    p_be_count_r6: assert property (@(posedge clk) disable iff (rst)
        pm_we |-> $countones(pm_be) == (pm_size == 2'd0 ? 1 : (pm_size == 2'd1 ? 2 : 4)));

    p_lane_copy_r6: assert property (@(posedge clk) disable iff (rst)
        (pm_we && pm_size == 2'd0) |-> pm_wdata[31:24] == pm_wdata[7:0]);

endmodule

bind pmw_port pmw_port_chk #(.BUS_AW(BUS_AW), .PM_AW(PM_AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .unlocked (key_ok),
    .pm_we    (pm_we),
    .pm_addr  (pm_addr),
    .pm_wdata (pm_wdata),
    .pm_be    (pm_be),
    .pm_size  (pm_size)
);

// File: tb/pmw_port_tb_top.sv
module pmw_port_tb_top;

    localparam int PM_AW = 18;
    localparam int NV    = 20;

    typedef struct packed {
        logic [31:0]      addr;
        logic [31:0]      data;
        logic [1:0]       size;
        logic             we;
        logic [PM_AW-1:0] pa;
        logic [3:0]       be;
        logic [31:0]      wd;
        logic [3:0]       rq;
    } vec_t;

    localparam logic [31:0] A_KEY = 32'h0001FC80;
    localparam logic [31:0] A_PTR = 32'h0001FC84;
    localparam logic [31:0] A_DAT = 32'h0001FC88;
    localparam logic [31:0] KEYV  = 32'h1337F7D1;

    localparam vec_t VECS [NV] = '{
        '{A_DAT, 32'hAABBCCDD, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd1}, // R1 locked at reset
        '{A_KEY, KEYV,         2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd2}, // R2 open
        '{A_DAT, 32'h11223344, 2'd2, 1'b1, 18'h0,     4'hF, 32'h11223344, 4'd1}, // R1 pointer zero
        '{A_PTR, 32'h00000100, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd4}, // R4 load
        '{A_DAT, 32'h000000A5, 2'd0, 1'b1, 18'h100,   4'h1, 32'hA5A5A5A5, 4'd6}, // R6 byte lane 0
        '{A_PTR, 32'h00000007, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd4},
        '{A_DAT, 32'h0000BEEF, 2'd1, 1'b1, 18'h6,     4'hC, 32'hBEEFBEEF, 4'd5}, // R5 half align
        '{A_DAT, 32'h0000005A, 2'd0, 1'b1, 18'hB,     4'h8, 32'h5A5A5A5A, 4'd4}, // R4 +4 after half
        '{A_DAT, 32'h01020304, 2'd2, 1'b1, 18'hC,     4'hF, 32'h01020304, 4'd5}, // R5 word align
        '{A_DAT, 32'hCAFEF00D, 2'd3, 1'b1, 18'h10,    4'hF, 32'hCAFEF00D, 4'd6}, // R6 code 3 as word
        '{32'h0001FC8C, 32'h0, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd7}, // R7 unused offset
        '{32'h0000FC88, 32'h1, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd7}, // R7 bit 16 clear
        '{32'h0003FC88, 32'h77, 2'd2, 1'b1, 18'h14,   4'hF, 32'h77,       4'd7}, // R7 high bits ignored
        '{A_KEY, 32'h1337F7D0, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd2}, // R2 wrong key closes
        '{A_DAT, 32'h55,       2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd2}, // R2 ignored when closed
        '{A_KEY, KEYV,         2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd2},
        '{A_DAT, 32'h99,       2'd2, 1'b1, 18'h18,    4'hF, 32'h99,       4'd4}, // R4 no step when locked
        '{A_PTR, 32'hFFFFFFFC, 2'd2, 1'b0, 18'h0,     4'h0, 32'h0,        4'd4},
        '{A_DAT, 32'h42,       2'd2, 1'b1, 18'h3FFFC, 4'hF, 32'h42,       4'd5}, // R5 low PM_AW bits
        '{A_DAT, 32'h11,       2'd0, 1'b1, 18'h0,     4'h1, 32'h11111111, 4'd4}  // R4 wrap to zero
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_we = 1'b0;
    logic [31:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [1:0]       bus_size = '0;
    logic             pm_we;
    logic [PM_AW-1:0] pm_addr;
    logic [31:0]      pm_wdata;
    logic [3:0]       pm_be;
    logic [1:0]       pm_size;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pmw_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_size  (bus_size),
        .pm_we     (pm_we),
        .pm_addr   (pm_addr),
        .pm_wdata  (pm_wdata),
        .pm_be     (pm_be),
        .pm_size   (pm_size)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = s;
        @(negedge clk);
    endtask

    task automatic idle();
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "we after reset", 32'(pm_we), 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d v%0d", VECS[i].rq, i);
            drive(VECS[i].addr, VECS[i].data, VECS[i].size);
            check(tag, "we", 32'(pm_we), 32'(VECS[i].we));
            if (VECS[i].we) begin
                check(tag, "addr", 32'(pm_addr), 32'(VECS[i].pa));
                check(tag, "be", 32'(pm_be), 32'(VECS[i].be));
                check(tag, "data", pm_wdata, VECS[i].wd);
            end
        end

        idle();
        check("R3", "strobe drops after one cycle", 32'(pm_we), 32'h0);

        // R3: a single write after an idle gap gives one pulse, then low
        drive(A_DAT, 32'hDEADBEEF, 2'd2);
        check("R3", "isolated pulse", 32'(pm_we), 32'h1);
        check("R3", "isolated addr", 32'(pm_addr), 32'h4);
        idle();
        check("R3", "isolated pulse end", 32'(pm_we), 32'h0);

        // R1: reset relocks and clears the pointer
        rst = 1'b1;
        idle();
        rst = 1'b0;
        drive(A_DAT, 32'h1, 2'd2);
        check("R1", "locked after mid-run reset", 32'(pm_we), 32'h0);
        drive(A_KEY, KEYV, 2'd2);
        drive(A_DAT, 32'h2, 2'd1);
        check("R1", "pointer zero after reset", 32'(pm_addr), 32'h0);
        check("R6", "half lanes at 0", 32'(pm_be), 32'h3);
        check("R6", "half data", pm_wdata, 32'h00020002);
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule